// File: doc/BRIEF.md
# Phase Lock Detector with Feedback Watchdog

This block decides whether a phase-locked loop is locked and reports the result on one status pin. Once per feedback clock cycle it receives a phase-error flag from an external comparator. The flag is high when the phase gap between reference and feedback is larger than the allowed delay limit, and it is already synchronous to the feedback clock. Lock has hysteresis in both directions. A long run of clean cycles is needed to report lock. A short run of bad cycles removes it.

A second path runs on the reference clock. It watches for feedback edges through a toggle that crosses the clock domains. When no feedback edge has arrived for a timeout measured in ticks of a divided reference clock, the watchdog forces the status low and holds the feedback-side logic in reset. When feedback returns, the block must again see the full run of clean cycles before it reports lock. The block needs a running reference clock; without one, the status has no defined meaning. Every pin is a plain level and there is no stream interface.

Top module: `lkd_lock_detect`

## Requirements
- R1: After reset `lock_o` is low and both run counters are zero. Reset is released into the feedback domain through a two-stage synchronizer, so the first two rising feedback edges after reset are not counted.
- R2: While unlocked, 32 consecutive counted feedback cycles with `phase_err_i` low drive `lock_o` high. 31 such cycles leave it low. The output follows the deciding feedback edge within eight reference clock cycles.
- R3: While locked, one to three consecutive error cycles leave `lock_o` high. The fourth consecutive error cycle drives it low.
- R4: While locked, a clean cycle restarts the error run. While unlocked, an error cycle restarts the clean run.
- R5: If no feedback edge reaches the reference domain for 64 ticks of the reference clock divided by 16, the watchdog trips and drives `lock_o` low. That is about 1024 reference cycles: the output is still high 900 cycles after the last edge and low 1100 cycles after it.
- R6: A feedback clock that keeps running never trips the watchdog, however long the run lasts.
- R7: After a trip, the first feedback edge clears the watchdog, and the two edges after it release the feedback-domain reset. Lock is then declared only after 32 further clean cycles, so the 35th clean edge after resume raises `lock_o` and the 34th does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Reference clock, used for the watchdog and the output register |
| fb_clk_i | input | 1 | Feedback clock, used for the run counters |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| phase_err_i | input | 1 | Phase-error flag for each feedback cycle, synchronous to fb_clk_i |
| lock_o | output | 1 | Lock status, synchronous to ref_clk_i |

## Verification
The bench steps the feedback clock one cycle at a time and sets the error flag for each cycle. This makes the run thresholds exact. One clean run of 31 cycles followed by a 32nd shows the lock boundary. Error runs of three, broken by a clean cycle and then extended to four, separate "consecutive" from "total" counting. A clean run broken by a single error proves that the clean counter restarts. Long idle gaps on the feedback clock, checked at 900 and at 1100 reference cycles, bound the watchdog timeout. A long unbroken clean run rules out false trips. A resume after a trip checks the count of edges that are discarded before the full relock rule applies.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
  localparam int unsigned LKD_LOCK_RUN      = 32;
  localparam int unsigned LKD_UNLOCK_RUN    = 4;
  localparam int unsigned LKD_PRE_DIV       = 16;
  localparam int unsigned LKD_TIMEOUT_TICKS = 64;
  localparam int unsigned LKD_SYNC_STAGES   = 2;
endpackage

// File: rtl/lkd_sync.sv
module lkd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) ff_q[s] <= 1'b0;
          else         ff_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) ff_q[s] <= 1'b0;
          else         ff_q[s] <= ff_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/lkd_run_fsm.sv
module lkd_run_fsm #(
  parameter int unsigned LOCK_RUN   = 32,
  parameter int unsigned UNLOCK_RUN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_i,
  output logic lock_o
);
  localparam int unsigned CW = (LOCK_RUN   > 1) ? $clog2(LOCK_RUN)   : 1;
  localparam int unsigned EW = (UNLOCK_RUN > 1) ? $clog2(UNLOCK_RUN) : 1;
  localparam logic [CW-1:0] CLEAN_LAST = CW'(LOCK_RUN - 1);
  localparam logic [EW-1:0] ERR_LAST   = EW'(UNLOCK_RUN - 1);

  logic          lock_q;
  logic [CW-1:0] clean_q;
  logic [EW-1:0] err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= 1'b0;
      clean_q <= '0;
      err_q   <= '0;
    end else if (!lock_q) begin
      err_q <= '0;
      if (err_i) begin
        clean_q <= '0;
      end else if (clean_q == CLEAN_LAST) begin
        clean_q <= '0;
        lock_q  <= 1'b1;
      end else begin
        clean_q <= clean_q + 1'b1;
      end
    end else begin
      clean_q <= '0;
      if (!err_i) begin
        err_q <= '0;
      end else if (err_q == ERR_LAST) begin
        err_q  <= '0;
        lock_q <= 1'b0;
      end else begin
        err_q <= err_q + 1'b1;
      end
    end
  end

  assign lock_o = lock_q;

  AST_LOCK_ON_CLEAN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_q && !err_i && clean_q == CLEAN_LAST) |=> lock_q); // R2
  AST_NO_EARLY_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_q && clean_q != CLEAN_LAST) |=> !lock_q); // R2
  AST_UNLOCK_ON_ERR_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && err_i && err_q == ERR_LAST) |=> !lock_q); // R3
  AST_SHORT_ERR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !(err_i && err_q == ERR_LAST)) |=> lock_q); // R3
  AST_ERR_RESTARTS_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_q && err_i) |=> (clean_q == '0)); // R4
  AST_CLEAN_RESTARTS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !err_i) |=> (err_q == '0)); // R4
endmodule

// File: rtl/lkd_watchdog.sv
module lkd_watchdog #(
  parameter int unsigned PRE_DIV       = 16,
  parameter int unsigned TIMEOUT_TICKS = 64,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fb_tgl_i,
  output logic tripped_o
);
  localparam int unsigned PW = (PRE_DIV       > 1) ? $clog2(PRE_DIV)       : 1;
  localparam int unsigned IW = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
  localparam logic [PW-1:0] PRE_LAST  = PW'(PRE_DIV - 1);
  localparam logic [IW-1:0] IDLE_LAST = IW'(TIMEOUT_TICKS - 1);

  logic          tgl_s;
  logic          tgl_prev_q;
  logic          act;
  logic [PW-1:0] pre_q;
  logic          tick;
  logic [IW-1:0] idle_q;
  logic          trip_q;

  lkd_sync #(.STAGES(SYNC_STAGES)) u_tgl_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (fb_tgl_i),
    .q_o    (tgl_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tgl_prev_q <= 1'b0;
    else         tgl_prev_q <= tgl_s;
  end

  assign act  = tgl_s ^ tgl_prev_q;
  assign tick = (pre_q == PRE_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pre_q <= '0;
    else if (tick) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= '0;
      trip_q <= 1'b0;
    end else if (act) begin
      idle_q <= '0;
      trip_q <= 1'b0;
    end else if (tick && !trip_q) begin
      if (idle_q == IDLE_LAST) begin
        idle_q <= '0;
        trip_q <= 1'b1;
      end else begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end

  assign tripped_o = trip_q;

  AST_TRIP_ON_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act && tick && !trip_q && idle_q == IDLE_LAST) |=> trip_q); // R5
  AST_NO_SPURIOUS_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trip_q && !(tick && idle_q == IDLE_LAST)) |=> !trip_q); // R6
  AST_ACTIVITY_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act |=> (!trip_q && idle_q == '0)); // R7
endmodule

// File: rtl/lkd_lock_detect.sv
module lkd_lock_detect
  import lkd_pkg::*;
#(
  parameter int unsigned LOCK_RUN      = LKD_LOCK_RUN,
  parameter int unsigned UNLOCK_RUN    = LKD_UNLOCK_RUN,
  parameter int unsigned PRE_DIV       = LKD_PRE_DIV,
  parameter int unsigned TIMEOUT_TICKS = LKD_TIMEOUT_TICKS,
  parameter int unsigned SYNC_STAGES   = LKD_SYNC_STAGES
) (
  input  logic ref_clk_i,
  input  logic fb_clk_i,
  input  logic rst_ni,
  input  logic phase_err_i,
  output logic lock_o
);
  logic fb_tgl_q;
  logic tripped;
  logic fb_arst_n;
  logic fb_rst_n;
  logic lock_fb;
  logic lock_fb_s;
  logic lock_q;

  // Toggle is kept out of the watchdog reset so feedback edges stay visible
  always_ff @(posedge fb_clk_i or negedge rst_ni) begin
    if (!rst_ni) fb_tgl_q <= 1'b0;
    else         fb_tgl_q <= ~fb_tgl_q;
  end

  lkd_watchdog #(
    .PRE_DIV       (PRE_DIV),
    .TIMEOUT_TICKS (TIMEOUT_TICKS),
    .SYNC_STAGES   (SYNC_STAGES)
  ) u_wdog (
    .clk_i     (ref_clk_i),
    .rst_ni    (rst_ni),
    .fb_tgl_i  (fb_tgl_q),
    .tripped_o (tripped)
  );

  // Feedback-side reset: asserted at once, released on feedback edges
  assign fb_arst_n = rst_ni & ~tripped;

  lkd_sync #(.STAGES(SYNC_STAGES)) u_fb_rst_sync (
    .clk_i  (fb_clk_i),
    .rst_ni (fb_arst_n),
    .d_i    (1'b1),
    .q_o    (fb_rst_n)
  );

  lkd_run_fsm #(
    .LOCK_RUN   (LOCK_RUN),
    .UNLOCK_RUN (UNLOCK_RUN)
  ) u_runs (
    .clk_i  (fb_clk_i),
    .rst_ni (fb_rst_n),
    .err_i  (phase_err_i),
    .lock_o (lock_fb)
  );

  lkd_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .d_i    (lock_fb),
    .q_o    (lock_fb_s)
  );

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b0;
    else         lock_q <= lock_fb_s & ~tripped;
  end

  assign lock_o = lock_q;

  AST_TRIP_DROPS_LOCK: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    tripped |=> !lock_o); // R5
  AST_LOCK_NEEDS_FB: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (!lock_fb_s) |=> !lock_o); // R2
endmodule

// File: tb/tb_lkd_lock_detect.sv
`timescale 1ns/1ps
module tb_lkd_lock_detect;
  logic ref_clk = 1'b0;
  logic fb_clk  = 1'b0;
  logic rst_n   = 1'b0;
  logic perr    = 1'b0;
  logic lock;
  int   checks  = 0;
  int   errors  = 0;

  always #4 ref_clk = ~ref_clk;

  lkd_lock_detect dut (
    .ref_clk_i   (ref_clk),
    .fb_clk_i    (fb_clk),
    .rst_ni      (rst_n),
    .phase_err_i (perr),
    .lock_o      (lock)
  );

  task automatic chk(input string rq, input logic exp);
    checks++;
    if (lock !== exp) begin
      errors++;
      $display("FAIL %s: lock_o=%0b expected %0b", rq, lock, exp);
    end
  endtask

  // One feedback cycle with the given phase-error flag
  task automatic fb_cycle(input logic e);
    perr = e;
    @(posedge ref_clk); #2;
    fb_clk = 1'b1;
    repeat (4) @(posedge ref_clk); #2;
    fb_clk = 1'b0;
    repeat (4) @(posedge ref_clk); #2;
  endtask

  task automatic fb_run(input int n, input logic e);
    for (int i = 0; i < n; i++) fb_cycle(e);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (5) @(posedge ref_clk); #2;
    chk("R1 reset", 1'b0);
    rst_n = 1'b1;
    repeat (3) @(posedge ref_clk); #2;
    chk("R1 after release", 1'b0);
  endtask

  task automatic t_first_lock;
    // two edges consumed by reset release, then 32 counted
    fb_run(33, 1'b0);
    chk("R1 R2 33 clean edges after reset", 1'b0);
    fb_cycle(1'b0);
    chk("R2 34th clean edge locks", 1'b1);
  endtask

  task automatic t_unlock;
    fb_run(3, 1'b1);
    chk("R3 three errors keep lock", 1'b1);
    fb_cycle(1'b0);
    chk("R4 clean cycle while locked", 1'b1);
    fb_run(3, 1'b1);
    chk("R4 error run restarted", 1'b1);
    fb_cycle(1'b1);
    chk("R3 fourth consecutive error unlocks", 1'b0);
  endtask

  task automatic t_clean_restart;
    fb_run(20, 1'b0);
    fb_cycle(1'b1);
    fb_run(31, 1'b0);
    chk("R4 clean run restarted by error", 1'b0);
    fb_cycle(1'b0);
    chk("R2 32 clean cycles relock", 1'b1);
  endtask

  task automatic t_long_run;
    int drops = 0;
    for (int i = 0; i < 200; i++) begin
      fb_cycle(1'b0);
      if (lock !== 1'b1) drops++;
    end
    checks++;
    if (drops != 0) begin
      errors++;
      $display("FAIL R6: lock low in %0d of 200 cycles, expected 0", drops);
    end
    chk("R6 lock after long run", 1'b1);
  endtask

  task automatic t_timeout;
    repeat (900) @(posedge ref_clk); #2;
    chk("R5 still locked at 900 idle cycles", 1'b1);
    repeat (200) @(posedge ref_clk); #2;
    chk("R5 watchdog dropped lock at 1100", 1'b0);
  endtask

  task automatic t_resume;
    fb_run(34, 1'b0);
    chk("R7 34 edges after resume", 1'b0);
    fb_cycle(1'b0);
    chk("R7 35th edge after resume locks", 1'b1);
  endtask

  initial begin
    t_reset();
    t_first_lock();
    t_unlock();
    t_clean_restart();
    t_long_run();
    t_timeout();
    t_resume();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge ref_clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule